// File: doc/BRIEF.md
# Pointer-Based Row Read Corrector

This block sits on the read path of a single memory row and repairs cells that are known to be permanently broken. Next to the data cells, the row stores a small repair record: one saturation flag and a set of repair slots. Each slot holds a cell address and one spare bit. The block works out which slots are live and, for every data position, picks the live slot of highest index that names it. It then returns the data with each named position adjusted by that slot's spare bit.

Correction is differential. The spare bit is XORed onto the stored cell, so a spare of 0 leaves the cell as stored. While the flag is clear, the last slot does not name a cell. Its bits instead hold a thermometer-coded count of how many of the other slots are in use. When the flag is set, every slot is live, the last one included. The block is purely combinational, with no state and no clock. The slot count and the row width are parameters, and the address width follows from the row width.

Top module: `ecp_row_read_fix`

## Requirements
- R1: The metadata word has the flag at bit 0. Slot k occupies bits [1+k*(P+1) +: P+1], where P = ceil(log2(DATA_W)). Bit 0 of each slot field is the spare bit and the upper P bits are the cell address, so a live slot selects exactly the one position equal to its address.
- R2: With the flag at 0, the low N-1 bits of the last slot field form a thermometer count starting at bit 0. Slot k (k <= N-2) is live only when count bits 0 through k are all 1. The first 0 ends the run, so ones above a gap are ignored, and the last slot is not live.
- R3: With the flag at 1, all N slots are live, including the last slot, whose field is then read as an address and spare bit.
- R4: `active_cnt` equals the number of live slots. That is N when the flag is 1; otherwise it is the length of the unbroken run of ones from bit 0 of the count.
- R5: A slot that is not live has no effect on any output bit, whatever its address and spare bit hold.
- R6: At a position selected by a live slot, the output bit is the stored bit XOR the winning slot's spare bit. A spare of 0 therefore returns the stored bit unchanged.
- R7: When several live slots name the same position, the slot with the highest index decides that position and all lower slots are ignored there.
- R8: A position named by no live slot passes the stored bit through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | DATA_W | Raw data cells read from the row |
| meta_in | input | 1+N_ENT*(P+1) | Raw repair record: flag and slot fields |
| data_out | output | DATA_W | Corrected row data |
| active_cnt | output | ceil(log2(N_ENT+1)) | Number of live repair slots |

## Verification
The assertions assume that the metadata is settled, two-state data. They also assume that N_ENT is between 2 and 8 and that a slot field is at least N_ENT-1 bits wide, so that the count fits in the last slot. The stimulus uses the default 512-bit row with six slots and builds every metadata word from explicit addresses, spare bits and count patterns. It covers gapped counts, an all-ones count, and several slots stacked on one address. It also places addresses and spare bits of 1 in dead slots, to show that they are ignored at the outputs.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

  localparam int MAX_ENTRIES = 8;
  localparam int RUN_VEC_W = 16;

  // Length of the unbroken run of ones starting at bit 0, looking at w bits.
  function automatic int unsigned run_length(input logic [RUN_VEC_W-1:0] v,
                                             input int unsigned w);
    int unsigned n;
    logic still;
    n = 0;
    still = 1'b1;
    for (int i = 0; i < RUN_VEC_W; i++) begin
      if (still && (i < int'(w)) && v[i]) n++;
      else still = 1'b0;
    end
    return n;
  endfunction

  // Low bit of slot k inside the metadata word.
  function automatic int unsigned slot_lsb(input int unsigned k,
                                           input int unsigned field_w);
    return 1 + k * field_w;
  endfunction

endpackage

// File: rtl/ecp_slot_status.sv
module ecp_slot_status #(
  parameter int N_ENT = 6,
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input  logic             full,
  input  logic [N_ENT-2:0] unary,
  output logic [N_ENT-1:0] active,
  output logic [CNT_W-1:0] count
);

  logic [N_ENT-2:0] run;

  assign run[0] = unary[0];

  genvar k;
  generate
    for (k = 1; k < N_ENT - 1; k++) begin : g_run
      assign run[k] = run[k-1] & unary[k];
    end
    for (k = 0; k < N_ENT - 1; k++) begin : g_act
      assign active[k] = full | run[k];
    end
  endgenerate

  assign active[N_ENT-1] = full;

  assign count = full ? CNT_W'(N_ENT)
                      : CNT_W'(ecp_pkg::run_length(ecp_pkg::RUN_VEC_W'(unary), N_ENT - 1));

  always_comb begin
    // R4
    cnt_match_chk: assert ($countones(active) == int'(count));
    // R3
    full_cnt_chk: assert (!full || (active == '1 && int'(count) == N_ENT));
  end

endmodule

// File: rtl/ecp_ptr_decoder.sv
module ecp_ptr_decoder #(
  parameter int DATA_W = 512,
  localparam int PTR_W = $clog2(DATA_W)
) (
  input  logic              en,
  input  logic [PTR_W-1:0]  ptr,
  output logic [DATA_W-1:0] hit
);

  genvar b;
  generate
    for (b = 0; b < DATA_W; b++) begin : g_pos
      assign hit[b] = en && (ptr == PTR_W'(b));
    end
  endgenerate

  always_comb begin
    // R1
    dec_onehot_chk: assert ($onehot0(hit));
    // R5
    dec_idle_chk: assert (en || hit == '0);
  end

endmodule

// File: rtl/ecp_prio_merge.sv
module ecp_prio_merge #(
  parameter int DATA_W = 512,
  parameter int N_ENT = 6
) (
  input  logic [N_ENT-1:0][DATA_W-1:0] hit,
  input  logic [N_ENT-1:0]             rep,
  output logic [DATA_W-1:0]            flip,
  output logic [DATA_W-1:0]            covered
);

  logic [N_ENT:0][DATA_W-1:0]   taken;
  logic [N_ENT:0][DATA_W-1:0]   acc;
  logic [N_ENT-1:0][DATA_W-1:0] win;

  assign taken[N_ENT] = '0;
  assign acc[N_ENT]   = '0;

  genvar k;
  generate
    for (k = N_ENT - 1; k >= 0; k--) begin : g_chain
      assign win[k]   = hit[k] & ~taken[k+1];
      assign taken[k] = taken[k+1] | hit[k];
      assign acc[k]   = acc[k+1] | (win[k] & {DATA_W{rep[k]}});
    end
  endgenerate

  assign flip    = acc[0];
  assign covered = taken[0];

  always_comb begin
    logic [N_ENT-1:0] col;
    for (int b = 0; b < DATA_W; b++) begin
      for (int j = 0; j < N_ENT; j++) col[j] = win[j][b];
      // R7
      single_winner_chk: assert ($onehot0(col));
      // R7
      winner_cover_chk: assert ((|col) == covered[b]);
    end
  end

endmodule

// File: rtl/ecp_row_read_fix.sv
module ecp_row_read_fix #(
  parameter int DATA_W = 512,
  parameter int N_ENT = 6,
  localparam int PTR_W = $clog2(DATA_W),
  localparam int FIELD_W = PTR_W + 1,
  localparam int META_W = 1 + N_ENT * FIELD_W,
  localparam int CNT_W = $clog2(N_ENT + 1)
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [META_W-1:0] meta_in,
  output logic [DATA_W-1:0] data_out,
  output logic [CNT_W-1:0]  active_cnt
);

  logic [N_ENT-1:0][FIELD_W-1:0] field;
  logic [N_ENT-1:0][PTR_W-1:0]   ptr;
  logic [N_ENT-1:0]              rep;
  logic [N_ENT-1:0]              active;
  logic [N_ENT-1:0][DATA_W-1:0]  hit;
  logic [DATA_W-1:0]             flip;
  logic [DATA_W-1:0]             covered;

  genvar k;
  generate
    for (k = 0; k < N_ENT; k++) begin : g_slot
      assign field[k] = meta_in[ecp_pkg::slot_lsb(k, FIELD_W) +: FIELD_W];
      assign ptr[k]   = field[k][FIELD_W-1:1];
      assign rep[k]   = field[k][0];

      ecp_ptr_decoder #(.DATA_W(DATA_W)) i_dec (
        .en  (active[k]),
        .ptr (ptr[k]),
        .hit (hit[k])
      );
    end
  endgenerate

  ecp_slot_status #(.N_ENT(N_ENT)) i_status (
    .full   (meta_in[0]),
    .unary  (field[N_ENT-1][N_ENT-2:0]),
    .active (active),
    .count  (active_cnt)
  );

  ecp_prio_merge #(.DATA_W(DATA_W), .N_ENT(N_ENT)) i_merge (
    .hit     (hit),
    .rep     (rep),
    .flip    (flip),
    .covered (covered)
  );

  assign data_out = data_in ^ flip;

  always_comb begin
    // R8
    passthru_chk: assert (((data_out ^ data_in) & ~covered) == '0);
    // R5
    idle_row_chk: assert (active != '0 || data_out == data_in);
  end

endmodule

// File: tb/test_ecp_row_read_fix.sv
module test_ecp_row_read_fix;

  localparam int DW = 512;
  localparam int NE = 6;
  localparam int FW = 10;
  localparam int MW = 1 + NE * FW;
  localparam int NV = 11;

  typedef struct packed {
    logic            full;
    logic [4:0]      unary;
    logic [5:0][8:0] ptr;
    logic [5:0]      rep;
    logic [3:0]      exp_cnt;
  } vec_t;

  // ptr given as {p5,p4,p3,p2,p1,p0}, rep as r5..r0
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'b00000, {9'd5, 9'd4, 9'd3, 9'd2, 9'd1, 9'd0},         6'b111111, 4'd0},
    '{1'b0, 5'b00001, {9'd9, 9'd8, 9'd7, 9'd6, 9'd3, 9'd2},         6'b111111, 4'd1},
    '{1'b0, 5'b00011, {9'd9, 9'd8, 9'd7, 9'd6, 9'd509, 9'd2},       6'b111111, 4'd2},
    '{1'b0, 5'b00011, {9'd1, 9'd1, 9'd1, 9'd1, 9'd7, 9'd7},         6'b111101, 4'd2},
    '{1'b0, 5'b00101, {9'd1, 9'd1, 9'd1, 9'd11, 9'd12, 9'd10},      6'b111111, 4'd1},
    '{1'b1, 5'b00000, {9'd511, 9'd400, 9'd300, 9'd200, 9'd100, 9'd0}, 6'b111111, 4'd6},
    '{1'b1, 5'b00000, {9'd33, 9'd33, 9'd33, 9'd33, 9'd33, 9'd33},   6'b110101, 4'd6},
    '{1'b1, 5'b00000, {9'd33, 9'd33, 9'd33, 9'd33, 9'd33, 9'd33},   6'b011111, 4'd6},
    '{1'b0, 5'b11111, {9'd0, 9'd4, 9'd3, 9'd2, 9'd1, 9'd0},         6'b111011, 4'd5},
    '{1'b0, 5'b11110, {9'd0, 9'd4, 9'd3, 9'd2, 9'd1, 9'd0},         6'b111111, 4'd0},
    '{1'b0, 5'b01111, {9'd0, 9'd300, 9'd511, 9'd2, 9'd1, 9'd0},     6'b111111, 4'd4}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic [MW-1:0] meta_in = '0;
  logic [DW-1:0] data_out;
  logic [2:0]    active_cnt;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ecp_row_read_fix i_ecp_row_read_fix (
    .data_in    (data_in),
    .meta_in    (meta_in),
    .data_out   (data_out),
    .active_cnt (active_cnt)
  );

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2/R5";
      1: return "R1/R6";
      2: return "R2/R8";
      3: return "R7/R6";
      4: return "R2";
      5: return "R3";
      6: return "R7";
      7: return "R6/R7";
      8: return "R2/R4";
      9: return "R2/R5";
      default: return "R5/R4";
    endcase
  endfunction

  function automatic logic [DW-1:0] pattern(input int i);
    logic [31:0] w = 32'h9E37_79B9 * (i + 1);
    return {16{w}};
  endfunction

  function automatic logic [MW-1:0] build_meta(input vec_t v);
    logic [MW-1:0] m = '0;
    m[0] = v.full;
    for (int k = 0; k < NE - 1; k++) m[1 + k*FW +: FW] = {v.ptr[k], v.rep[k]};
    if (v.full) m[1 + (NE-1)*FW +: FW] = {v.ptr[NE-1], v.rep[NE-1]};
    else        m[1 + (NE-1)*FW +: FW] = {5'b0, v.unary};
    return m;
  endfunction

  function automatic logic slot_live(input vec_t v, input int k);
    logic all_set = 1'b1;
    if (v.full) return 1'b1;
    if (k == NE - 1) return 1'b0;
    for (int j = 0; j <= k; j++) all_set = all_set & v.unary[j];
    return all_set;
  endfunction

  // Ascending walk with overwrite: the last live slot naming a position decides it.
  function automatic logic [DW-1:0] expect_data(input vec_t v, input logic [DW-1:0] raw);
    logic [DW-1:0] d = raw;
    for (int k = 0; k < NE; k++)
      if (slot_live(v, k)) d[v.ptr[k]] = raw[v.ptr[k]] ^ v.rep[k];
    return d;
  endfunction

  task automatic check_data(input string tag, input logic [DW-1:0] exp);
    tests++;
    if (data_out !== exp) begin
      fails++;
      $display("FAIL %s data: got %h expected %h", tag, data_out, exp);
    end
  endtask

  task automatic check_cnt(input string tag, input int exp);
    tests++;
    if (int'(active_cnt) != exp) begin
      fails++;
      $display("FAIL %s active_cnt: got %0d expected %0d", tag, active_cnt, exp);
    end
  endtask

  task automatic apply(input logic [DW-1:0] d, input logic [MW-1:0] m);
    @(negedge clk);
    data_in = d;
    meta_in = m;
    #2;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [MW-1:0] m;
    logic [DW-1:0] d;
    repeat (3) @(posedge clk);
    // Reset state: idle inputs give idle outputs (R8, R4)
    #2;
    check_data("R8 reset", '0);
    check_cnt("R4 reset", 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      d = pattern(i);
      apply(d, build_meta(VECS[i]));
      check_data(vec_tag(i), expect_data(VECS[i], d));
      check_cnt(vec_tag(i), int'(VECS[i].exp_cnt));
    end

    // R3: last slot acts as a pointer when full; clears bit 511 of all-ones
    m = '0;
    m[0] = 1'b1;
    m[1 + 5*FW +: FW] = {9'd511, 1'b1};
    d = '1;
    apply(d, m);
    d[511] = 1'b0;
    check_data("R3 last-slot", d);
    check_cnt("R3 last-slot", 6);

    // R7: five stacked slots at position 50, top live slot (4) has spare 1
    m = '0;
    for (int k = 0; k < 5; k++) m[1 + k*FW +: FW] = {9'd50, (k % 2 == 0) ? 1'b1 : 1'b0};
    m[1 + 5*FW +: FW] = {5'b0, 5'b11111};
    d = '0;
    apply(d, m);
    d[50] = 1'b1;
    check_data("R7 stacked", d);

    // R5: dead slots (count 0) with spares 1 at varied addresses leave data alone
    m = '0;
    for (int k = 0; k < 5; k++) m[1 + k*FW +: FW] = {9'(k * 97 + 3), 1'b1};
    d = pattern(20);
    apply(d, m);
    check_data("R5 dead-slots", d);
    check_cnt("R5 dead-slots", 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule